// File: doc/BRIEF.md
# Configuration and Startup Sequencer

This block steps a programmable device from power-up to user operation. Once the power-on indication is good, it clears the configuration memory and then waits on a shared open-drain init line. While the init line is low it does not accept data. When the line is released it samples the mode pins, which set the load width and the clocking role. It then counts incoming configuration bits against a fixed length and strobes a frame write each time a frame fills.

After the last frame, the block pulses a global set/reset for one cycle. It can then pause until the clock-manager lock inputs are good. Next it releases its open-drain done line, and on the two following cycles it releases the global three-state and then the global write enable. The three-state release can also be made to wait for the shared done line, so that chained devices come up together. A low on the program request restarts the whole sequence from the clear phase. An unsupported mode code parks the block with init held low until the next program request.

The configuration memory itself is not part of the block. It is stood in for by a bit counter and by the frame strobes.

Top module: `cfg_seq_top`

## Requirements
- R1: After reset the block waits for `por_good`. It then holds `cfg_clear` high for exactly CLEAR_CYCLES cycles, and `init_drive_low` is high throughout that time and while waiting for `por_good`.
- R2: After the clear count the block releases `init_drive_low`. It does not begin loading while the sensed `init_in` is low. Loading starts on the cycle after `init_in` is seen high.
- R3: The mode pins are sampled as {M2,M1,M0} when loading starts. 000 is master serial (1 bit), 111 is slave serial (1 bit), 011 is master parallel (8 bits), 110 is slave parallel (8 bits) and 101 is boundary scan (1 bit, no clock driven).
- R4: The codes 001, 010 and 100 send the block to an error state. There `init_drive_low` stays high, no loading takes place and the done line stays driven low until `prog_n` goes low.
- R5: In the load phase each cycle with `din_valid` high adds 1 or 8 bits, according to the mode. The phase ends on the cycle whose data brings the count to TOTAL_BITS. Outside the load phase `din_valid` has no effect.
- R6: `frame_wr` is high in the same cycle as the `din_valid` that completes each block of FRAME_BITS bits.
- R7: `gsr` is high for exactly one cycle, the cycle after the final frame write.
- R8: With `opt_wait_lock` high, startup waits after `gsr` until all `lock_in` bits are high (`opt_lock_all` high) or any one is high (`opt_lock_all` low). With `opt_wait_lock` low it does not wait.
- R9: `done_drive_low` falls when startup proceeds. `gts` falls one cycle later and `gwe` rises one cycle after that.
- R10: With `opt_wait_done` high, `gts` stays high until the sensed `done_in` is high, and falls on the cycle after `done_in` is first seen high.
- R11: `prog_n` low in any state other than the power-on wait restarts the sequence in the clear phase. That restart re-asserts `gts`, drops `gwe`, drives done low and forgets the latched mode.
- R12: Once a mode is latched, `cclk_out_en` is high for the master modes (000, 011) and `dout_en` is high for the serial modes (000, 111). `dout` takes `din[0]` one cycle after each accepted serial load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_good | input | 1 | Supplies have reached operating level |
| prog_n | input | 1 | Active-low program (restart) request |
| init_in | input | 1 | Sensed level of the shared open-drain init line |
| mode_pins | input | 3 | Mode select {M2,M1,M0} |
| din | input | 8 | Configuration data; bit 0 carries serial data |
| din_valid | input | 1 | Data strobe |
| lock_in | input | NUM_LOCK | Clock-manager lock indications |
| done_in | input | 1 | Sensed level of the shared done line |
| opt_wait_lock | input | 1 | Hold startup until the lock condition holds |
| opt_lock_all | input | 1 | Lock condition needs all inputs (1) or any input (0) |
| opt_wait_done | input | 1 | Hold three-state release until the done line is high |
| init_drive_low | output | 1 | Pull the init line low |
| done_drive_low | output | 1 | Pull the done line low |
| cfg_clear | output | 1 | Configuration memory clear strobe |
| frame_wr | output | 1 | Frame write strobe |
| gsr | output | 1 | Global set/reset pulse |
| gts | output | 1 | Global three-state (high holds outputs off) |
| gwe | output | 1 | Global write enable |
| cclk_out_en | output | 1 | Block drives the configuration clock |
| dout_en | output | 1 | Serial pass-through enabled |
| dout | output | 1 | Serial pass-through data |

## Verification
The case that is hardest to reach from the ports is a restart that lands in the middle of a load, after some frames have already been written. A later full load must then count from zero, not from the bits already seen. The bench drives three bytes in a parallel mode, pulls `prog_n` low, completes a fresh serial load and checks that the frame strobes and `gsr` land at the positions of a clean count. Holding the init and done lines low from outside is done by wiring each line in the bench as the AND of the block's release and an external hold. The reference model sees the same wired value.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [3:0] {
    ST_POR,
    ST_CLEAR,
    ST_INIT_WAIT,
    ST_LOAD,
    ST_GSR,
    ST_LOCK_WAIT,
    ST_DONE_REL,
    ST_GTS_REL,
    ST_RUN,
    ST_ERR
  } seq_state_e;

  typedef struct packed {
    logic valid;
    logic wide;
    logic master;
    logic serial;
  } mode_info_t;

  localparam logic [2:0] PIN_MSTR_SER = 3'b000;
  localparam logic [2:0] PIN_SLV_SER  = 3'b111;
  localparam logic [2:0] PIN_MSTR_PAR = 3'b011;
  localparam logic [2:0] PIN_SLV_PAR  = 3'b110;
  localparam logic [2:0] PIN_JTAG     = 3'b101;

endpackage

// File: rtl/cfg_mode_dec.sv
module cfg_mode_dec
  import cfg_seq_pkg::*;
(
  input  logic [2:0] mode_pins,
  output mode_info_t info
);

  always_comb begin
    info = '0;
    unique case (mode_pins)
      PIN_MSTR_SER: info = '{valid: 1'b1, wide: 1'b0, master: 1'b1, serial: 1'b1};
      PIN_SLV_SER:  info = '{valid: 1'b1, wide: 1'b0, master: 1'b0, serial: 1'b1};
      PIN_MSTR_PAR: info = '{valid: 1'b1, wide: 1'b1, master: 1'b1, serial: 1'b0};
      PIN_SLV_PAR:  info = '{valid: 1'b1, wide: 1'b1, master: 1'b0, serial: 1'b0};
      PIN_JTAG:     info = '{valid: 1'b1, wide: 1'b0, master: 1'b0, serial: 1'b0};
      default:      info = '0;
    endcase
  end

endmodule

// File: rtl/cfg_load_ctr.sv
module cfg_load_ctr #(
  parameter int TOTAL_BITS = 64,
  parameter int FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic wide,
  input  logic din_valid,
  output logic frame_wr,
  output logic last_take
);

  localparam int CNT_W = $clog2(TOTAL_BITS + 9);
  localparam int FR_W  = $clog2(FRAME_BITS + 9);

  logic [CNT_W-1:0] bit_cnt_q, bit_cnt_d, bit_sum;
  logic [FR_W-1:0]  frm_cnt_q, frm_cnt_d, frm_sum;
  logic             take;

  assign take    = active & din_valid;
  assign bit_sum = bit_cnt_q + (wide ? CNT_W'(8) : CNT_W'(1));
  assign frm_sum = frm_cnt_q + (wide ? FR_W'(8) : FR_W'(1));

  assign frame_wr  = take & (frm_sum == FR_W'(FRAME_BITS));
  assign last_take = take & (bit_sum >= CNT_W'(TOTAL_BITS));

  always_comb begin
    bit_cnt_d = bit_cnt_q;
    frm_cnt_d = frm_cnt_q;
    if (!active) begin
      bit_cnt_d = '0;
      frm_cnt_d = '0;
    end else if (take) begin
      bit_cnt_d = bit_sum;
      frm_cnt_d = frame_wr ? '0 : frm_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      frm_cnt_q <= '0;
    end else begin
      bit_cnt_q <= bit_cnt_d;
      frm_cnt_q <= frm_cnt_d;
    end
  end

endmodule

// File: rtl/cfg_startup_gate.sv
module cfg_startup_gate #(
  parameter int NUM_LOCK = 2
) (
  input  logic [NUM_LOCK-1:0] lock_in,
  input  logic                opt_wait_lock,
  input  logic                opt_lock_all,
  input  logic                opt_wait_done,
  input  logic                done_in,
  output logic                lock_ok,
  output logic                done_ok
);

  logic all_locked, any_locked;

  generate
    if (NUM_LOCK == 1) begin : g_single
      assign all_locked = lock_in[0];
      assign any_locked = lock_in[0];
    end else begin : g_multi
      assign all_locked = &lock_in;
      assign any_locked = |lock_in;
    end
  endgenerate

  assign lock_ok = !opt_wait_lock || (opt_lock_all ? all_locked : any_locked);
  assign done_ok = !opt_wait_done || done_in;

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
#(
  parameter int CLEAR_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_good,
  input  logic       prog_n,
  input  logic       init_in,
  input  logic       mode_valid,
  input  logic       last_take,
  input  logic       lock_ok,
  input  logic       done_ok,
  output seq_state_e state,
  output logic       restart,
  output logic       latch_mode
);

  localparam int CL_W = $clog2(CLEAR_CYCLES + 1);

  seq_state_e       state_q, state_d;
  logic [CL_W-1:0]  clr_cnt_q, clr_cnt_d;
  logic             clr_end;

  assign state   = state_q;
  assign restart = !prog_n && (state_q != ST_POR);
  assign clr_end = (clr_cnt_q == CL_W'(CLEAR_CYCLES - 1));
  assign latch_mode = !restart && (state_q == ST_INIT_WAIT) && init_in && mode_valid;

  always_comb begin
    state_d   = state_q;
    clr_cnt_d = clr_cnt_q;
    if (restart) begin
      state_d   = ST_CLEAR;
      clr_cnt_d = '0;
    end else begin
      unique case (state_q)
        ST_POR: begin
          if (por_good) begin
            state_d   = ST_CLEAR;
            clr_cnt_d = '0;
          end
        end
        ST_CLEAR: begin
          if (clr_end) state_d = ST_INIT_WAIT;
          else         clr_cnt_d = clr_cnt_q + CL_W'(1);
        end
        ST_INIT_WAIT: begin
          if (init_in) state_d = mode_valid ? ST_LOAD : ST_ERR;
        end
        ST_LOAD:      if (last_take) state_d = ST_GSR;
        ST_GSR:       state_d = ST_LOCK_WAIT;
        ST_LOCK_WAIT: if (lock_ok) state_d = ST_DONE_REL;
        ST_DONE_REL:  if (done_ok) state_d = ST_GTS_REL;
        ST_GTS_REL:   state_d = ST_RUN;
        ST_RUN:       state_d = ST_RUN;
        ST_ERR:       state_d = ST_ERR;
        default:      state_d = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_POR;
      clr_cnt_q <= '0;
    end else begin
      state_q   <= state_d;
      clr_cnt_q <= clr_cnt_d;
    end
  end

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int TOTAL_BITS   = 64,
  parameter int FRAME_BITS   = 16,
  parameter int CLEAR_CYCLES = 4,
  parameter int NUM_LOCK     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                por_good,
  input  logic                prog_n,
  input  logic                init_in,
  input  logic [2:0]          mode_pins,
  input  logic [7:0]          din,
  input  logic                din_valid,
  input  logic [NUM_LOCK-1:0] lock_in,
  input  logic                done_in,
  input  logic                opt_wait_lock,
  input  logic                opt_lock_all,
  input  logic                opt_wait_done,
  output logic                init_drive_low,
  output logic                done_drive_low,
  output logic                cfg_clear,
  output logic                frame_wr,
  output logic                gsr,
  output logic                gts,
  output logic                gwe,
  output logic                cclk_out_en,
  output logic                dout_en,
  output logic                dout
);

  mode_info_t pin_info;
  mode_info_t mode_q, mode_d;
  seq_state_e state;
  logic       restart, latch_mode, last_take, lock_ok, done_ok;
  logic       loading, serial_take;
  logic       dout_q, dout_d;

  cfg_mode_dec u_dec (
    .mode_pins (mode_pins),
    .info      (pin_info)
  );

  cfg_startup_gate #(.NUM_LOCK(NUM_LOCK)) u_gate (
    .lock_in       (lock_in),
    .opt_wait_lock (opt_wait_lock),
    .opt_lock_all  (opt_lock_all),
    .opt_wait_done (opt_wait_done),
    .done_in       (done_in),
    .lock_ok       (lock_ok),
    .done_ok       (done_ok)
  );

  cfg_seq_fsm #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_good   (por_good),
    .prog_n     (prog_n),
    .init_in    (init_in),
    .mode_valid (pin_info.valid),
    .last_take  (last_take),
    .lock_ok    (lock_ok),
    .done_ok    (done_ok),
    .state      (state),
    .restart    (restart),
    .latch_mode (latch_mode)
  );

  assign loading = (state == ST_LOAD);

  cfg_load_ctr #(.TOTAL_BITS(TOTAL_BITS), .FRAME_BITS(FRAME_BITS)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (loading),
    .wide      (mode_q.wide),
    .din_valid (din_valid),
    .frame_wr  (frame_wr),
    .last_take (last_take)
  );

  // mode latch: captured on entry to load, forgotten on restart
  always_comb begin
    mode_d = mode_q;
    if (restart)         mode_d = '0;
    else if (latch_mode) mode_d = pin_info;
  end

  assign serial_take = loading && din_valid && mode_q.serial;

  always_comb begin
    dout_d = dout_q;
    if (serial_take) dout_d = din[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dout_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dout_q <= dout_d;
    end
  end

  // outputs decoded from the state register
  assign init_drive_low = (state == ST_POR) || (state == ST_CLEAR) || (state == ST_ERR);
  assign cfg_clear      = (state == ST_CLEAR);
  assign gsr            = (state == ST_GSR);
  assign done_drive_low = !((state == ST_DONE_REL) || (state == ST_GTS_REL) || (state == ST_RUN));
  assign gts            = !((state == ST_GTS_REL) || (state == ST_RUN));
  assign gwe            = (state == ST_RUN);
  assign cclk_out_en    = mode_q.valid && mode_q.master;
  assign dout_en        = mode_q.valid && mode_q.serial;
  assign dout           = dout_q;

endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
  parameter int NUM_LOCK = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                prog_n,
  input logic                din_valid,
  input logic [NUM_LOCK-1:0] lock_in,
  input logic                done_in,
  input logic                opt_wait_lock,
  input logic                opt_lock_all,
  input logic                opt_wait_done,
  input logic                init_drive_low,
  input logic                done_drive_low,
  input logic                cfg_clear,
  input logic                frame_wr,
  input logic                gsr,
  input logic                gts,
  input logic                gwe
);

  a_r1_clear_holds_init: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |-> init_drive_low);

  a_r5_frame_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wr |-> (din_valid && !cfg_clear && !init_drive_low));

  a_r7_gsr_single: assert property (@(posedge clk) disable iff (!rst_n)
    gsr |=> !gsr);

  a_r7_gsr_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gsr) |-> $past(frame_wr));

  a_r8_lock_all_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(done_drive_low) && $past(opt_wait_lock && opt_lock_all)) |-> $past(&lock_in));

  a_r8_lock_any_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(done_drive_low) && $past(opt_wait_lock && !opt_lock_all)) |-> $past(|lock_in));

  a_r9_gts_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gts) |-> (!done_drive_low && $past(!done_drive_low)));

  a_r9_gwe_after_gts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gwe) |-> (!gts && $past(!gts)));

  a_r10_wait_shared_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gts) && $past(opt_wait_done)) |-> $past(done_in));

  a_r11_restart_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |=> (gts && !gwe && done_drive_low));

endmodule

bind cfg_seq_top cfg_seq_chk #(.NUM_LOCK(NUM_LOCK)) i_chk (.*);

// File: tb/test_cfg_seq_top.sv
module test_cfg_seq_top;

  localparam int TOTAL = 64;
  localparam int FRAME = 16;
  localparam int CLRN  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       por_good = 1'b0, prog_n = 1'b1;
  logic       hold_init = 1'b0, hold_done = 1'b0;
  logic [2:0] mode_pins = 3'b011;
  logic [7:0] din = 8'h00;
  logic       din_valid = 1'b0;
  logic [1:0] lock_in = 2'b00;
  logic       opt_wait_lock = 1'b0, opt_lock_all = 1'b0, opt_wait_done = 1'b0;

  logic init_drive_low, done_drive_low, cfg_clear, frame_wr, gsr, gts, gwe;
  logic cclk_out_en, dout_en, dout;
  logic init_line, done_line;

  assign init_line = ~(init_drive_low | hold_init);
  assign done_line = ~(done_drive_low | hold_done);

  always #4 clk = ~clk;

  cfg_seq_top i_cfg_seq_top (
    .clk(clk), .rst_n(rst_n), .por_good(por_good), .prog_n(prog_n),
    .init_in(init_line), .mode_pins(mode_pins), .din(din), .din_valid(din_valid),
    .lock_in(lock_in), .done_in(done_line), .opt_wait_lock(opt_wait_lock),
    .opt_lock_all(opt_lock_all), .opt_wait_done(opt_wait_done),
    .init_drive_low(init_drive_low), .done_drive_low(done_drive_low),
    .cfg_clear(cfg_clear), .frame_wr(frame_wr), .gsr(gsr), .gts(gts), .gwe(gwe),
    .cclk_out_en(cclk_out_en), .dout_en(dout_en), .dout(dout)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit armed = 0;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phases: "por","clear","initwait","load","gsr","lockwait","donerel","gtsrel","run","err"
  string ph = "por";
  int    clr_left = 0, bits = 0;
  bit    m_valid = 0, m_wide = 0, m_master = 0, m_serial = 0;
  logic  m_dout = 1'b0;

  function automatic bit m_init_low();
    return (ph == "por") || (ph == "clear") || (ph == "err");
  endfunction
  function automatic bit m_done_low();
    return !((ph == "donerel") || (ph == "gtsrel") || (ph == "run"));
  endfunction
  function automatic int m_step();
    return m_wide ? 8 : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = "por"; clr_left = 0; bits = 0;
      m_valid = 0; m_wide = 0; m_master = 0; m_serial = 0; m_dout = 1'b0;
    end else begin
      bit iin, din_ok;
      iin = !(m_init_low() || hold_init);
      din_ok = !(m_done_low() || hold_done);
      if (!prog_n && ph != "por") begin
        ph = "clear"; clr_left = CLRN; m_valid = 0; m_wide = 0; m_master = 0; m_serial = 0;
      end else if (ph == "por") begin
        if (por_good) begin ph = "clear"; clr_left = CLRN; end
      end else if (ph == "clear") begin
        clr_left--;
        if (clr_left == 0) ph = "initwait";
      end else if (ph == "initwait") begin
        if (iin) begin
          case (mode_pins)
            3'b000: begin m_valid = 1; m_wide = 0; m_master = 1; m_serial = 1; end
            3'b111: begin m_valid = 1; m_wide = 0; m_master = 0; m_serial = 1; end
            3'b011: begin m_valid = 1; m_wide = 1; m_master = 1; m_serial = 0; end
            3'b110: begin m_valid = 1; m_wide = 1; m_master = 0; m_serial = 0; end
            3'b101: begin m_valid = 1; m_wide = 0; m_master = 0; m_serial = 0; end
            default: m_valid = 0;
          endcase
          ph = m_valid ? "load" : "err";
          bits = 0;
        end
      end else if (ph == "load") begin
        if (din_valid) begin
          bits += m_step();
          if (m_serial) m_dout = din[0];
          if (bits >= TOTAL) ph = "gsr";
        end
      end else if (ph == "gsr") begin
        ph = "lockwait";
      end else if (ph == "lockwait") begin
        if (!opt_wait_lock || (opt_lock_all ? (lock_in == 2'b11) : (lock_in != 2'b00)))
          ph = "donerel";
      end else if (ph == "donerel") begin
        if (!opt_wait_done || din_ok) ph = "gtsrel";
      end else if (ph == "gtsrel") begin
        ph = "run";
      end
    end
  end

  // compare every cycle, away from the active edge
  always begin
    @(negedge clk);
    #2;
    if (armed) begin
      bit fw;
      fw = (ph == "load") && din_valid && (((bits + m_step()) % FRAME) == 0);
      chk("R1", "cfg_clear", cfg_clear, ph == "clear");
      chk("R2", "init_drive_low", init_drive_low, m_init_low());
      chk("R6", "frame_wr", frame_wr, fw);
      chk("R7", "gsr", gsr, ph == "gsr");
      chk("R9", "done_drive_low", done_drive_low, m_done_low());
      chk("R9", "gts", gts, !((ph == "gtsrel") || (ph == "run")));
      chk("R9", "gwe", gwe, ph == "run");
      chk("R12", "cclk_out_en", cclk_out_en, m_valid && m_master);
      chk("R12", "dout_en", dout_en, m_valid && m_serial);
      chk("R12", "dout", dout, m_dout);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic restart_with(input logic [2:0] m);
    prog_n = 1'b0; mode_pins = m; tick(2); prog_n = 1'b1;
  endtask

  task automatic feed(input int n, input bit gaps, input int seed);
    for (int i = 0; i < n; i++) begin
      din = 8'(seed + i * 37); din[0] = ((i + seed) % 3) == 0; din_valid = 1'b1; tick();
      if (gaps) begin din_valid = 1'b0; tick(); end
    end
    din_valid = 1'b0;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    armed = 1;
    tick(1);
    chk("R1", "reset gts", gts, 1'b1);
    chk("R1", "reset gwe", gwe, 1'b0);

    // A: parallel master, init held externally, all-lock wait, shared-done wait
    opt_wait_lock = 1; opt_lock_all = 1; opt_wait_done = 1;
    hold_init = 1; hold_done = 1;
    din_valid = 1'b1; tick(3); din_valid = 1'b0;   // R5: ignored before load
    por_good = 1'b1;
    tick(12);
    chk("R2", "held in clear, no clock role yet", cclk_out_en, 1'b0);
    hold_init = 0;
    tick(2);
    feed(8, 1, 5);
    tick(3);
    lock_in = 2'b01; tick(3);
    chk("R8", "one lock of two not enough", done_drive_low, 1'b1);
    lock_in = 2'b11; tick(3);
    chk("R10", "gts waits on shared done", gts, 1'b1);
    hold_done = 0; tick(3);
    chk("R9", "running after release", gwe, 1'b1);

    // B: master serial, no waits
    opt_wait_lock = 0; opt_wait_done = 0; lock_in = 2'b00;
    restart_with(3'b000);
    chk("R11", "restart drops gwe", gwe, 1'b0);
    tick(CLRN + 2);
    feed(64, 0, 2);
    tick(5);
    chk("R9", "serial run", gwe, 1'b1);

    // C: unused code -> error
    restart_with(3'b100);
    tick(CLRN + 8);
    chk("R4", "error holds init", init_drive_low, 1'b1);
    din_valid = 1'b1; tick(3); din_valid = 1'b0;
    chk("R4", "error keeps done low", done_drive_low, 1'b1);

    // D: slave parallel, restart mid-load, then slave serial with any-lock
    opt_wait_lock = 1; opt_lock_all = 0;
    restart_with(3'b110);
    tick(CLRN + 2);
    feed(3, 0, 9);
    restart_with(3'b111);
    tick(CLRN + 2);
    feed(64, 1, 4);
    tick(3);
    chk("R8", "waiting for any lock", done_drive_low, 1'b1);
    lock_in = 2'b10; tick(4);
    chk("R8", "any lock releases", gwe, 1'b1);

    // E: boundary scan code, 1 bit wide, no clock drive
    opt_wait_lock = 0; lock_in = 2'b00;
    restart_with(3'b101);
    tick(CLRN + 2);
    feed(63, 0, 1);
    chk("R5", "one bit short still loading", gsr, 1'b0);
    feed(1, 0, 1);
    chk("R7", "gsr after final bit", gsr, 1'b1);
    tick(4);
    chk("R3", "scan mode no clock drive", cclk_out_en, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule